// File: doc/BRIEF.md
# Switchable-Period Watchdog Supervisor with Wake-Up Monitoring

This block supervises a microprocessor from a single system clock. The processor proves it is alive by producing rising edges on a trigger line. The block resets the processor whenever an edge fails to arrive within the current watchdog window. A mode line selects between a fixed short window and a long window. When the long window is selected, a two-bit time-select field picks its length.

Six wake-up lines are synchronised and debounced. While the long window is selected, any accepted change on any of them, rising or falling, also resets the processor. This lets a sleeping processor with a slow watchdog be woken by external events. A peripheral enable output is granted only once the processor has produced three accepted triggers since the last reset. Every reset withdraws it again.

All windows are counted in ticks. A tick is one pulse of an internal divider that fires every `TICK_DIV` clocks. All asynchronous inputs pass through a `SYNC_STAGES`-deep synchroniser before use.

Top module: `wdg_wake_supervisor`

## Requirements
- R1: After `rst_n` is released, `proc_rst_o` and `periph_en_o` are low, the short window is in force and the accepted-trigger count is zero.
- R2: A trigger is a rising edge of `trig_i` after synchronisation. A line held high counts once and does not keep restarting the window.
- R3: With `mode_i` low, the window is `SHORT_TICKS` ticks. `proc_rst_o` rises exactly `SHORT_TICKS` ticks after the clock edge at which the last trigger was accepted. With the bench configuration, that is `SYNC_STAGES + 1 + SHORT_TICKS` clocks after `trig_i` is raised.
- R4: With `mode_i` high, the window is `LONG_BASE << tsel_i` ticks. Here `tsel_i` is an unsigned value from 0 to 3.
- R5: Each reset pulse on `proc_rst_o` lasts exactly `RST_CYCLES` clocks. After it ends, a fresh window starts.
- R6: `periph_en_o` rises on the third accepted trigger since the last reset. It stays high while triggers keep coming and is low for the whole of every reset pulse.
- R7: Trigger edges that arrive while `proc_rst_o` is high are neither counted nor used to restart the window.
- R8: A wake-up line's debounced value changes only after the synchronised input has held the new level for `DEB_TICKS` consecutive ticks. A shorter excursion, including one of `DEB_TICKS-1` ticks, is ignored.
- R9: In long mode, a debounced rising or falling change on any of the six wake-up lines (`wake_i[i]`, bit i is line i) starts a reset pulse.
- R10: In short mode, debounced wake-up changes have no effect on `proc_rst_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing derives from it |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| trig_i | input | 1 | Processor alive signal; rising edge is a trigger |
| mode_i | input | 1 | 0 selects the short window, 1 the long window |
| tsel_i | input | TSEL_W | Long-window length select, `LONG_BASE << tsel_i` ticks |
| wake_i | input | N_WAKE | Wake-up lines, debounced, edge-sensitive in long mode |
| proc_rst_o | output | 1 | Active-high processor reset pulse |
| periph_en_o | output | 1 | Peripheral enable, granted after three accepted triggers |

## Verification
The bench builds the block with `TICK_DIV=1`, `SHORT_TICKS=16` and `LONG_BASE=32`, keeping `DEB_TICKS=4` and `RST_CYCLES=16`. With one tick per clock, every window and debounce interval becomes an exact clock count that the bench predicts arithmetically. The short windows keep all four long-window lengths (up to 256 clocks) within a sweep of a few hundred cycles. This lets the bench sweep every `tsel_i` value, both edge directions on all six wake-up lines, and debounce excursions on either side of the `DEB_TICKS` boundary.

// File: rtl/wdg_pkg.sv
// Package: shared types for the watchdog supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package wdg_pkg;

    // Window selection as seen by the period counter.
    typedef enum logic {
        WD_SHORT = 1'b0,
        WD_LONG  = 1'b1
    } wd_mode_e;

    // Length in ticks of the longest window reachable through the select field.
    function automatic int max_window(input int long_base, input int tsel_w);
        return long_base << ((1 << tsel_w) - 1);
    endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
// Module: wdg_tick_gen
// Produces a one-clock tick every DIV clocks; all windows count these ticks.
// Assumes: DIV >= 1; with DIV == 1 the tick is permanently high.
module wdg_tick_gen #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV == 1) begin : g_every_clock
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick_o    = 1'b1;
        end else begin : g_divider
            localparam int DW = $clog2(DIV);
            logic [DW-1:0] div_q;

            // Free-running divider; wraps after DIV clocks.
            always_ff @(posedge clk) begin
                if (!rst_n)                       div_q <= '0;
                else if (div_q == DW'(DIV - 1))   div_q <= '0;
                else                              div_q <= div_q + DW'(1);
            end

            assign tick_o = (div_q == DW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/wdg_sync.sv
// Module: wdg_sync
// Multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes: each bit is sampled separately; no bus coherency is implied.
module wdg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the inputs through STAGES flops, clearing to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_debounce.sv
// Module: wdg_debounce
// Debounces one synchronised line on tick boundaries and flags each accepted change.
// Assumes: input already synchronised; the line rests low after reset.
module wdg_debounce #(
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic d_i,
    output logic change_o
);
    localparam int CW = $clog2(DEB_TICKS + 1);

    logic          cand_q;
    logic          stable_q;
    logic [CW-1:0] run_q;
    logic          settle;

    // The candidate has now been seen for DEB_TICKS ticks in a row.
    assign settle = tick_i && (d_i == cand_q) && (run_q == CW'(DEB_TICKS - 1));

    // Track the run length of the current candidate level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= 1'b0;
            run_q  <= CW'(DEB_TICKS);
        end else if (tick_i) begin
            if (d_i != cand_q) begin
                cand_q <= d_i;
                run_q  <= CW'(1);
            end else if (run_q < CW'(DEB_TICKS)) begin
                run_q  <= run_q + CW'(1);
            end
        end
    end

    // Commit the settled level and flag a change for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            change_o <= 1'b0;
        end else begin
            change_o <= settle && (stable_q != cand_q);
            if (settle) stable_q <= cand_q;
        end
    end
endmodule

// File: rtl/wdg_period.sv
// Module: wdg_period
// Counts ticks since the last restart and flags expiry of the selected window.
// Assumes: tsel is quasi-static; restart and hold have priority over expiry.
module wdg_period
    import wdg_pkg::*;
#(
    parameter int SHORT_TICKS = 64,
    parameter int LONG_BASE   = 256,
    parameter int TSEL_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic              hold_i,
    input  wd_mode_e          mode_i,
    input  logic [TSEL_W-1:0] tsel_i,
    output logic              expire_o
);
    localparam int LMAX = max_window(LONG_BASE, TSEL_W);
    localparam int CW   = $clog2(LMAX) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Window length in ticks for the current selection.
    always_comb begin
        if (mode_i == WD_LONG) lim = CW'(LONG_BASE) << tsel_i;
        else                   lim = CW'(SHORT_TICKS);
    end

    // Last tick of the window passed without a restart.
    assign expire_o = tick_i && !hold_i && !restart_i && (cnt_q >= lim - CW'(1));

    // Tick counter, cleared by restart, hold or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (hold_i || restart_i || expire_o) cnt_q <= '0;
        else if (tick_i)                         cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/wdg_ctrl.sv
// Module: wdg_ctrl
// Generates the processor reset pulse and grants the peripheral enable.
// Assumes: expire and wake_hit are single-clock requests; pulse ignores new requests.
module wdg_ctrl #(
    parameter int RST_CYCLES = 16,
    parameter int GOOD_TRIGS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_acc_i,
    input  logic expire_i,
    input  logic wake_hit_i,
    output logic pulse_o,
    output logic en_o
);
    localparam int PW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam int GW = $clog2(GOOD_TRIGS + 1);

    logic [PW-1:0] left_q;
    logic [GW-1:0] good_q;

    // Reset pulse sequencing and trigger counting in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
            left_q  <= '0;
            good_q  <= '0;
            en_o    <= 1'b0;
        end else if (pulse_o) begin
            if (left_q == '0) pulse_o <= 1'b0;
            else              left_q  <= left_q - PW'(1);
            good_q <= '0;
            en_o   <= 1'b0;
        end else if (wake_hit_i || expire_i) begin
            pulse_o <= 1'b1;
            left_q  <= PW'(RST_CYCLES - 1);
            good_q  <= '0;
            en_o    <= 1'b0;
        end else if (trig_acc_i) begin
            if (good_q < GW'(GOOD_TRIGS)) good_q <= good_q + GW'(1);
            en_o <= (good_q >= GW'(GOOD_TRIGS - 1));
        end
    end
endmodule

// File: rtl/wdg_wake_supervisor.sv
// Module: wdg_wake_supervisor (top)
// Watchdog with short/long windows, debounced wake-up reset and enable gating.
// Assumes: all data inputs are asynchronous except tsel_i, which is quasi-static.
module wdg_wake_supervisor
    import wdg_pkg::*;
#(
    parameter int N_WAKE      = 6,
    parameter int TICK_DIV    = 16,
    parameter int SHORT_TICKS = 64,
    parameter int LONG_BASE   = 256,
    parameter int TSEL_W      = 2,
    parameter int DEB_TICKS   = 4,
    parameter int RST_CYCLES  = 16,
    parameter int GOOD_TRIGS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              mode_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic [N_WAKE-1:0] wake_i,
    output logic              proc_rst_o,
    output logic              periph_en_o
);
    localparam int SW = N_WAKE + 2;

    logic              tick;
    logic [SW-1:0]     sync_q;
    logic              trig_s;
    logic              trig_prev_q;
    logic              trig_acc;
    logic              mode_long;
    wd_mode_e          mode_sel;
    logic [N_WAKE-1:0] wake_edge;
    logic              wake_hit;
    logic              expire;

    wdg_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    wdg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({mode_i, trig_i, wake_i}),
        .q_o(sync_q)
    );

    assign trig_s    = sync_q[N_WAKE];
    assign mode_long = sync_q[N_WAKE+1];
    assign mode_sel  = mode_long ? WD_LONG : WD_SHORT;

    // Remember the previous synchronised trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev_q <= 1'b0;
        else        trig_prev_q <= trig_s;
    end

    assign trig_acc = trig_s && !trig_prev_q && !proc_rst_o;

    generate
        for (genvar i = 0; i < N_WAKE; i++) begin : g_wake
            wdg_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
                .clk(clk), .rst_n(rst_n), .tick_i(tick),
                .d_i(sync_q[i]), .change_o(wake_edge[i])
            );
        end
    endgenerate

    assign wake_hit = mode_long && (|wake_edge);

    wdg_period #(
        .SHORT_TICKS(SHORT_TICKS), .LONG_BASE(LONG_BASE), .TSEL_W(TSEL_W)
    ) u_period (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .restart_i(trig_acc), .hold_i(proc_rst_o),
        .mode_i(mode_sel), .tsel_i(tsel_i), .expire_o(expire)
    );

    wdg_ctrl #(.RST_CYCLES(RST_CYCLES), .GOOD_TRIGS(GOOD_TRIGS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .trig_acc_i(trig_acc), .expire_i(expire), .wake_hit_i(wake_hit),
        .pulse_o(proc_rst_o), .en_o(periph_en_o)
    );
endmodule

// File: rtl/wdg_sva.sv
// Module: wdg_sva
// Property checker bound into the supervisor top; observes ports and the
// nets that join its sub-blocks.
module wdg_sva #(
    parameter int N_WAKE     = 6,
    parameter int RST_CYCLES = 16,
    parameter int GOOD_TRIGS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_rst_o,
    input logic              periph_en_o,
    input logic              trig_acc,
    input logic              expire,
    input logic              mode_long,
    input logic [N_WAKE-1:0] wake_edge
);
    logic [7:0] high_run;
    logic [7:0] acc_seen;

    // Length of the current reset pulse so far.
    always_ff @(posedge clk) begin
        if (!rst_n)          high_run <= '0;
        else if (proc_rst_o) high_run <= high_run + 8'd1;
        else                 high_run <= '0;
    end

    // Accepted triggers since the last reset pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || proc_rst_o)                  acc_seen <= '0;
        else if (trig_acc && acc_seen < 8'd200)    acc_seen <= acc_seen + 8'd1;
    end

    p_rst_not_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
        proc_rst_o |-> (high_run < 8'(RST_CYCLES)));

    p_rst_full_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(proc_rst_o) |-> (high_run == 8'(RST_CYCLES)));

    p_en_off_in_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        proc_rst_o |-> !periph_en_o);

    p_en_needs_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en_o |-> (acc_seen >= 8'(GOOD_TRIGS)));

    p_en_rise_on_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_en_o) |-> $past(trig_acc));

    p_rst_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_rst_o) |-> $past(expire || (mode_long && (|wake_edge))));
endmodule

bind wdg_wake_supervisor wdg_sva #(
    .N_WAKE(N_WAKE), .RST_CYCLES(RST_CYCLES), .GOOD_TRIGS(GOOD_TRIGS)
) u_sva (
    .clk(clk), .rst_n(rst_n),
    .proc_rst_o(proc_rst_o), .periph_en_o(periph_en_o),
    .trig_acc(trig_acc), .expire(expire),
    .mode_long(mode_long), .wake_edge(wake_edge)
);

// File: tb/sim_wdg_wake_supervisor.sv
module sim_wdg_wake_supervisor;
    localparam int SHORT = 16;
    localparam int LBASE = 32;
    localparam int RSTC  = 16;
    localparam int LAT   = 3;   // two sync stages plus the accepting edge

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic       mode = 1'b0;
    logic [1:0] tsel = 2'd0;
    logic [5:0] wake = 6'd0;
    logic       prst;
    logic       pen;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdg_wake_supervisor #(
        .N_WAKE(6), .TICK_DIV(1), .SHORT_TICKS(SHORT), .LONG_BASE(LBASE),
        .TSEL_W(2), .DEB_TICKS(4), .RST_CYCLES(RSTC), .GOOD_TRIGS(3),
        .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .mode_i(mode),
        .tsel_i(tsel), .wake_i(wake), .proc_rst_o(prst), .periph_en_o(pen)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pause(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rst_end();
        while (prst) @(negedge clk);
        pause(2);
    endtask

    // Raise trig, hold it for 'hold' cycles, count clocks until reset rises.
    task automatic timeout_run(input int hold, output int k);
        @(negedge clk);
        trig = 1'b1;
        k = 0;
        while (!prst && k < 2000) begin
            @(negedge clk);
            k++;
            if (k == hold) trig = 1'b0;
        end
        trig = 1'b0;
    endtask

    task automatic trig_pulse();
        @(negedge clk);
        trig = 1'b1;
        pause(3);
        trig = 1'b0;
        pause(3);
    endtask

    task automatic watch_rst(input int n, output bit seen);
        seen = 1'b0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (prst) seen = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int  k;
        int  w;
        bit  seen;

        pause(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        check(prst == 1'b0, "R1 reset low", int'(prst), 0);
        check(pen == 1'b0, "R1 enable low", int'(pen), 0);

        // R3: short window timeout
        timeout_run(3, k);
        check(k == LAT + SHORT, "R3 short window", k, LAT + SHORT);

        // R5: pulse width
        w = 0;
        while (prst && w < 100) begin
            @(negedge clk);
            w++;
        end
        check(w == RSTC, "R5 pulse width", w, RSTC);

        // R2: a held trigger counts once
        pause(2);
        timeout_run(40, k);
        check(k == LAT + SHORT, "R2 held trigger", k, LAT + SHORT);

        // R7: triggers during the pulse are ignored
        for (int j = 0; j < 2; j++) begin
            trig = 1'b1; pause(2);
            trig = 1'b0; pause(2);
        end
        wait_rst_end();
        trig_pulse();
        trig_pulse();
        pause(2);
        check(pen == 1'b0, "R7 pulse triggers not counted", int'(pen), 0);
        trig_pulse();
        check(pen == 1'b1, "R6 third trigger grants enable", int'(pen), 1);
        for (int j = 0; j < 3; j++) trig_pulse();
        check(pen == 1'b1, "R6 enable held while triggering", int'(pen), 1);
        while (!prst) @(negedge clk);
        check(pen == 1'b0, "R6 enable low in reset", int'(pen), 0);
        wait_rst_end();
        check(pen == 1'b0, "R6 enable low after reset", int'(pen), 0);

        // R4: long window sweep over every select value
        mode = 1'b1;
        for (int t = 0; t < 4; t++) begin
            tsel = 2'(t);
            wait_rst_end();
            timeout_run(3, k);
            check(k == LAT + (LBASE << t), "R4 long window", k, LAT + (LBASE << t));
        end

        // R8: debounce boundary on line 0
        tsel = 2'd3;
        wait_rst_end();
        trig_pulse();
        wake[0] = 1'b1; pause(2); wake[0] = 1'b0;
        watch_rst(14, seen);
        check(seen == 1'b0, "R8 two-tick glitch ignored", int'(seen), 0);
        wake[0] = 1'b1; pause(3); wake[0] = 1'b0;
        watch_rst(14, seen);
        check(seen == 1'b0, "R8 three-tick glitch ignored", int'(seen), 0);
        wake[0] = 1'b1; pause(4); wake[0] = 1'b0;
        watch_rst(14, seen);
        check(seen == 1'b1, "R8 four-tick level accepted", int'(seen), 1);
        wait_rst_end();
        pause(8);

        // R9: both edge directions on each line in long mode
        for (int i = 0; i < 6; i++) begin
            trig_pulse();
            wake[i] = 1'b1;
            watch_rst(14, seen);
            check(seen == 1'b1, $sformatf("R9 rise line %0d", i), int'(seen), 1);
            wait_rst_end();
            trig_pulse();
            wake[i] = 1'b0;
            watch_rst(14, seen);
            check(seen == 1'b1, $sformatf("R9 fall line %0d", i), int'(seen), 1);
            wait_rst_end();
        end

        // R10: wake-up changes ignored in short mode
        mode = 1'b0;
        pause(3);
        trig_pulse();
        wake[2] = 1'b1;
        watch_rst(8, seen);
        check(seen == 1'b0, "R10 short-mode rise ignored", int'(seen), 0);
        trig_pulse();
        wake[2] = 1'b0;
        watch_rst(8, seen);
        check(seen == 1'b0, "R10 short-mode fall ignored", int'(seen), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule